// File: doc/BRIEF.md
# Serial Command Decoder

This block sits behind a byte-wide serial receiver and turns the incoming byte stream into commands for a capture engine. A byte whose most significant bit is clear is a complete one-byte command. It is decoded into a single-cycle pulse: device reset, arm, identify, pause transmit or resume transmit. A byte whose most significant bit is set opens a five-byte command. That byte is the opcode, and the next four bytes form a 32-bit argument. The opcode and the argument are then handed to the configuration logic together, with a one-cycle strobe.

Long and short commands share one stream. While argument bytes are still owed, every byte is taken as argument data, whatever its value. This is why a host that has lost track of the framing sends the reset byte five times. The first bytes use up whatever arguments were still pending, and at least the last one is decoded as a reset.

The identify command also starts a four-byte reply on a ready/valid transmit port. The reply is three ASCII letters ("SLA") followed by an ASCII protocol version digit.

Top module: `serial_cmd_decoder`

## Requirements
- R1: With no argument bytes pending, an accepted byte with bit 7 clear is a short command. Codes 00h, 01h, 02h, 11h and 13h raise `rst_pulse`, `arm_pulse`, `ident_pulse`, `resume_pulse` and `pause_pulse` respectively. The pulse is high for exactly the one cycle after the clock edge that accepted the byte.
- R2: Any other short code (bit 7 clear) raises no pulse, no `cfg_valid` and no reply, and leaves framing idle, so the next byte is decoded as a fresh command.
- R3: With no arguments pending, an accepted byte with bit 7 set is an opcode. The next four accepted bytes are argument data and raise no short-command pulse, whatever their values.
- R4: In the cycle after the edge that accepts the fourth argument byte, `cfg_valid` is high for one cycle. `cfg_opcode` then holds the opcode and `cfg_arg` holds the argument, with the first argument byte in bits 7:0 and the fourth in bits 31:24.
- R5: Five consecutive 00h bytes always produce at least one `rst_pulse`, on the last of them, whatever number (0 to 4) of argument bytes was pending.
- R6: One cycle after `ident_pulse`, `tx_valid` rises and the bytes 53h, 4Ch, 41h, 31h are offered in order. Each is held stable while `tx_ready` is low, and each is taken on a cycle with both `tx_valid` and `tx_ready` high. After the fourth byte is taken, `tx_valid` falls.
- R7: An identify command that arrives while a reply is in progress is ignored. The reply in progress continues and no second reply follows.
- R8: A reset command abandons a reply in progress, and `tx_valid` is low from the cycle after `rst_pulse`.
- R9: While `rst_n` is low, all pulses, `cfg_valid` and `tx_valid` are low and no arguments are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rst_pulse | output | 1 | Device reset command |
| arm_pulse | output | 1 | Arm trigger command |
| ident_pulse | output | 1 | Identify command |
| pause_pulse | output | 1 | Pause transmit command |
| resume_pulse | output | 1 | Resume transmit command |
| cfg_valid | output | 1 | Long command complete strobe |
| cfg_opcode | output | 8 | Long command opcode |
| cfg_arg | output | 32 | Long command argument, first byte least significant |
| tx_valid | output | 1 | Identification reply byte offered |
| tx_data | output | 8 | Identification reply byte |
| tx_ready | input | 1 | Transmitter takes the offered byte |

## Verification
Short-command pulses and `cfg_valid` are due in the cycle right after the clock edge that samples the byte. The bench drives each byte on a falling edge, removes it on the next falling edge and samples the outputs there. The first reply byte appears one cycle later than `ident_pulse`, so the bench expects `tx_valid` still low at the sampling point of the identify byte and high one cycle after that. An abort by reset takes effect one further cycle after `rst_pulse`, and the bench checks `tx_valid` both at the pulse and one cycle later. The sweeps cover all 128 short codes, all 128 opcodes with argument bytes that mimic short codes, and reset recovery from every pending-argument count.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [6:0] SC_RESET  = 7'h00;
    localparam logic [6:0] SC_ARM    = 7'h01;
    localparam logic [6:0] SC_IDENT  = 7'h02;
    localparam logic [6:0] SC_RESUME = 7'h11;
    localparam logic [6:0] SC_PAUSE  = 7'h13;

    typedef struct packed {
        logic rst;
        logic arm;
        logic ident;
        logic pause;
        logic resume;
    } short_cmd_t;

    localparam int unsigned ID_LEN = 4;

    function automatic logic [BYTE_W-1:0] id_char(input logic [1:0] idx,
                                                  input logic [BYTE_W-1:0] ver);
        logic [BYTE_W-1:0] c;
        case (idx)
            2'd0:    c = 8'h53;
            2'd1:    c = 8'h4C;
            2'd2:    c = 8'h41;
            default: c = ver;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scd_frame.sv
module scd_frame #(
    parameter int unsigned ARG_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    output logic                   short_stb,
    output logic [6:0]             short_code,
    output logic                   long_stb,
    output logic [7:0]             long_op,
    output logic [8*ARG_BYTES-1:0] long_arg
);
    localparam int unsigned ARG_W = 8 * ARG_BYTES;
    localparam int unsigned CNT_W = $clog2(ARG_BYTES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic [7:0]       op;
        logic [ARG_W-1:0] arg;
        logic             sstb;
        logic [6:0]       scode;
        logic             lstb;
    } frame_t;

    frame_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sstb = 1'b0;
        st_d.lstb = 1'b0;
        if (rx_valid) begin
            if (st_q.left != '0) begin
                st_d.arg  = {rx_data, st_q.arg[ARG_W-1:8]};
                st_d.left = st_q.left - CNT_W'(1);
                if (st_q.left == CNT_W'(1)) begin
                    st_d.lstb = 1'b1;
                end
            end else if (rx_data[7]) begin
                st_d.op   = rx_data;
                st_d.arg  = '0;
                st_d.left = CNT_W'(ARG_BYTES);
            end else begin
                st_d.sstb  = 1'b1;
                st_d.scode = rx_data[6:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign short_stb  = st_q.sstb;
    assign short_code = st_q.scode;
    assign long_stb   = st_q.lstb;
    assign long_op    = st_q.op;
    assign long_arg   = st_q.arg;

endmodule

// File: rtl/scd_short_dec.sv
module scd_short_dec
    import scd_pkg::*;
(
    input  logic       stb,
    input  logic [6:0] code,
    output short_cmd_t cmd
);
    always_comb begin
        cmd        = '0;
        cmd.rst    = stb && (code == SC_RESET);
        cmd.arm    = stb && (code == SC_ARM);
        cmd.ident  = stb && (code == SC_IDENT);
        cmd.resume = stb && (code == SC_RESUME);
        cmd.pause  = stb && (code == SC_PAUSE);
    end
endmodule

// File: rtl/scd_id_seq.sv
module scd_id_seq
    import scd_pkg::*;
#(
    parameter logic [7:0] VERSION_CHAR = 8'h31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data
);
    localparam int unsigned IDX_W = $clog2(ID_LEN);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (abort) begin
            sq_d.active = 1'b0;
        end else if (!sq_q.active) begin
            if (start) begin
                sq_d.active = 1'b1;
                sq_d.idx    = '0;
            end
        end else if (tx_ready) begin
            if (sq_q.idx == IDX_W'(ID_LEN - 1)) begin
                sq_d.active = 1'b0;
            end else begin
                sq_d.idx = sq_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign tx_valid = sq_q.active;
    assign tx_data  = id_char(2'(sq_q.idx), VERSION_CHAR);

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import scd_pkg::*;
#(
    parameter int unsigned ARG_BYTES    = 4,
    parameter logic [7:0]  VERSION_CHAR = 8'h31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    output logic                   rst_pulse,
    output logic                   arm_pulse,
    output logic                   ident_pulse,
    output logic                   pause_pulse,
    output logic                   resume_pulse,
    output logic                   cfg_valid,
    output logic [7:0]             cfg_opcode,
    output logic [8*ARG_BYTES-1:0] cfg_arg,
    output logic                   tx_valid,
    output logic [7:0]             tx_data,
    input  logic                   tx_ready
);
    logic       sstb;
    logic [6:0] scode;
    short_cmd_t cmd;

    scd_frame #(.ARG_BYTES(ARG_BYTES)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .short_stb  (sstb),
        .short_code (scode),
        .long_stb   (cfg_valid),
        .long_op    (cfg_opcode),
        .long_arg   (cfg_arg)
    );

    scd_short_dec u_dec (
        .stb  (sstb),
        .code (scode),
        .cmd  (cmd)
    );

    scd_id_seq #(.VERSION_CHAR(VERSION_CHAR)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd.ident),
        .abort    (cmd.rst),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    assign rst_pulse    = cmd.rst;
    assign arm_pulse    = cmd.arm;
    assign ident_pulse  = cmd.ident;
    assign pause_pulse  = cmd.pause;
    assign resume_pulse = cmd.resume;

endmodule

// File: rtl/scd_checker.sv
module scd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rst_pulse,
    input logic       arm_pulse,
    input logic       ident_pulse,
    input logic       pause_pulse,
    input logic       resume_pulse,
    input logic       cfg_valid,
    input logic [7:0] cfg_opcode,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready
);
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_pulse, arm_pulse, ident_pulse, pause_pulse, resume_pulse, cfg_valid})); // R3

    AST_SHORT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse || arm_pulse || ident_pulse || pause_pulse || resume_pulse) |-> $past(rx_valid)); // R1

    AST_CFG_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(rx_valid)); // R4

    AST_CFG_OPCODE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_opcode[7]); // R3

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !rst_pulse) |=> (tx_valid && $stable(tx_data))); // R6

    AST_REPLY_STARTS_S: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == 8'h53)); // R6

    AST_REPLY_AFTER_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(ident_pulse)); // R6

    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !tx_valid); // R8
endmodule

bind serial_cmd_decoder scd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rst_pulse    (rst_pulse),
    .arm_pulse    (arm_pulse),
    .ident_pulse  (ident_pulse),
    .pause_pulse  (pause_pulse),
    .resume_pulse (resume_pulse),
    .cfg_valid    (cfg_valid),
    .cfg_opcode   (cfg_opcode),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_ready     (tx_ready)
);

// File: tb/sim_serial_cmd_decoder.sv
module sim_serial_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_ready = 1'b1;
    logic        rst_pulse, arm_pulse, ident_pulse, pause_pulse, resume_pulse;
    logic        cfg_valid;
    logic [7:0]  cfg_opcode;
    logic [31:0] cfg_arg;
    logic        tx_valid;
    logic [7:0]  tx_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rst_pulse(rst_pulse), .arm_pulse(arm_pulse), .ident_pulse(ident_pulse),
        .pause_pulse(pause_pulse), .resume_pulse(resume_pulse),
        .cfg_valid(cfg_valid), .cfg_opcode(cfg_opcode), .cfg_arg(cfg_arg),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] pulses();
        return {rst_pulse, arm_pulse, ident_pulse, pause_pulse, resume_pulse};
    endfunction

    // drive on a falling edge, sample at the next falling edge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain_reply(input string req);
        logic [7:0] exp [4];
        exp[0] = 8'h53; exp[1] = 8'h4C; exp[2] = 8'h41; exp[3] = 8'h31;
        tx_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk(tx_valid && tx_data == exp[i], req, {23'd0, tx_valid, tx_data}, {24'd1, exp[i]});
            @(negedge clk);
        end
        chk(!tx_valid, req, {31'd0, tx_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        rx_valid = 1'b1;
        rx_data  = 8'h02;
        idle(3);
        chk(pulses() == 5'd0 && !cfg_valid && !tx_valid, "R9",
            {25'd0, pulses(), cfg_valid, tx_valid}, 32'd0);
        rx_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);
        chk(pulses() == 5'd0 && !cfg_valid && !tx_valid, "R9 after release",
            {25'd0, pulses(), cfg_valid, tx_valid}, 32'd0);

        // R1 / R2: sweep every short code
        for (int c = 0; c < 128; c++) begin
            logic [4:0] exp;
            exp = {c == 8'h00, c == 8'h01, c == 8'h02, c == 8'h13, c == 8'h11};
            send(8'(c));
            chk(pulses() == exp && !cfg_valid, (exp == 0) ? "R2" : "R1",
                {26'd0, cfg_valid, pulses()}, {27'd0, exp});
            if (c != 2) chk(!tx_valid, "R2 no reply", {31'd0, tx_valid}, 32'd0);
            @(negedge clk);
            chk(pulses() == 5'd0, "R1 single cycle", {27'd0, pulses()}, 32'd0);
            idle(5);
        end

        // R3 / R4: every opcode, argument bytes that look like short codes
        for (int o = 128; o < 256; o++) begin
            logic [7:0]  op;
            logic [31:0] arg;
            op  = 8'(o);
            arg = {op + 8'd7, ~op, op ^ 8'h3C, op & 8'h13};
            send(op);
            chk(pulses() == 5'd0 && !cfg_valid, "R3 opcode", {26'd0, cfg_valid, pulses()}, 32'd0);
            for (int k = 0; k < 4; k++) begin
                send(arg[8*k +: 8]);
                chk(pulses() == 5'd0, "R3 argument", {27'd0, pulses()}, 32'd0);
                if (k < 3) chk(!cfg_valid, "R4 early", {31'd0, cfg_valid}, 32'd0);
            end
            chk(cfg_valid && cfg_opcode == op, "R4 opcode", {23'd0, cfg_valid, cfg_opcode}, {24'd1, op});
            chk(cfg_arg == arg, "R4 argument", cfg_arg, arg);
            @(negedge clk);
            chk(!cfg_valid, "R4 single cycle", {31'd0, cfg_valid}, 32'd0);
        end

        // R5: recovery from every pending count
        for (int k = 0; k <= 4; k++) begin
            int rs;
            int cv;
            rs = 0;
            cv = 0;
            send(8'h81);
            for (int j = 0; j < k; j++) send(8'hA5);
            if (k == 4) cv++;
            for (int j = 0; j < 5; j++) begin
                send(8'h00);
                if (rst_pulse) rs++;
                if (cfg_valid) cv++;
                if (j == 4) chk(rst_pulse, "R5 last reset", {31'd0, rst_pulse}, 32'd1);
            end
            chk(rs == (k + 1), "R5 reset count", rs, k + 1);
            chk(cv == 1, "R5 pending command closed", cv, 1);
        end

        // R6: reply held under back-pressure
        tx_ready = 1'b0;
        send(8'h02);
        chk(ident_pulse && !tx_valid, "R6 latency", {30'd0, ident_pulse, tx_valid}, 32'd2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tx_valid && tx_data == 8'h53, "R6 hold", {23'd0, tx_valid, tx_data}, 32'h153);
        end
        // R7: second identify ignored
        send(8'h02);
        chk(tx_valid && tx_data == 8'h53, "R7 busy", {23'd0, tx_valid, tx_data}, 32'h153);
        drain_reply("R6 sequence");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!tx_valid, "R7 no second reply", {31'd0, tx_valid}, 32'd0);
        end

        // R6 with alternating ready
        send(8'h02);
        begin
            int got;
            logic [7:0] exp [4];
            exp[0] = 8'h53; exp[1] = 8'h4C; exp[2] = 8'h41; exp[3] = 8'h31;
            got = 0;
            for (int cyc = 0; cyc < 12; cyc++) begin
                @(negedge clk);
                tx_ready = cyc[0];
                if (tx_valid && tx_ready) begin
                    if (got < 4)
                        chk(tx_data == exp[got], "R6 ready toggling", {24'd0, tx_data}, {24'd0, exp[got]});
                    got++;
                end
            end
            chk(got == 4, "R6 byte count", got, 4);
        end

        // R8: reset aborts a reply
        idle(2);
        tx_ready = 1'b0;
        send(8'h02);
        @(negedge clk);
        chk(tx_valid, "R8 reply active", {31'd0, tx_valid}, 32'd1);
        send(8'h00);
        chk(rst_pulse && tx_valid, "R8 pulse", {30'd0, rst_pulse, tx_valid}, 32'd3);
        @(negedge clk);
        chk(!tx_valid, "R8 abort", {31'd0, tx_valid}, 32'd0);
        tx_ready = 1'b1;
        idle(4);
        chk(!tx_valid, "R8 stays idle", {31'd0, tx_valid}, 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule